// File: doc/BRIEF.md
# Safe System Clock Source Switch

This block picks the system clock from five oscillator sources and changes between them without glitches. A small register port holds the source select code, one enable bit per source, a prescaler setting, a lock bit, and per-source failure enables and flags. A select write takes effect only when the target source is enabled and reports ready. A source that still drives the system clock cannot be switched off.

The changeover uses one gate cell per source. Each cell is clocked by its own source. The outgoing gate closes on its own clock edges, and only then does the incoming gate open on the incoming clock's edges. The result is that the output clock never carries a shortened pulse during a normal switch.

The ready line of the PLL and the ready line of the external source double as lock and liveness monitors. When failure detection is on for a source and that source fails while it drives the system clock, the block falls back to the 2 MHz source, restores the enable and select registers to their reset values, records the failure and pulses the NMI output. When the failing source is not in use, the block only clears that source's enable bit and records the failure.

Top module: `safe_clk_switch`

## Requirements
- R1: After a synchronous reset (rst_n low at a reg_clk edge):
  - the select code is 0 and the enable vector is 5'b00001;
  - the prescaler, the lock bit, both failure-detect enables, both failure flags and nmi are 0;
  - the clock gate of source 0 then opens, so active_src becomes 5'b00001.
- R2: The select code maps 0 to the 2 MHz source, 1 to the 32 MHz source, 2 to the 32.768 kHz source, 3 to the external source and 4 to the PLL.
  - An accepted write to address 0 (code in wr_data[2:0]) updates sel_code at the next reg_clk edge.
  - sys_clk then runs at the period of src_clk[code].
- R3: A select write is ignored when the target's src_rdy bit is low or its enable bit is low.
- R4: Select codes 5, 6 and 7 are reserved. Writes of them are ignored and the current code is kept.
- R5: Some writes change state only when cfg_unlock is high in the same cycle as wr_en:
  - the select write (address 0);
  - the prescaler write (address 2, wr_data[6:0]);
  - the lock and failure-enable bits (address 3, bits 0, 1, 2).
  Enable writes (address 1, wr_data[4:0], bit i for source code i) and flag clears need no unlock.
- R6: An enable write sets or clears bits freely, with one exception. A zero written to the bit of the selected source, or of any source whose gate is still open, leaves that bit at 1.
- R7: During a switch:
  - the old gate closes after two edges of the old clock, and the new gate opens after two edges of the new clock once the old gate is closed;
  - sys_clk never shows a pulse shorter than half the fastest source period;
  - switch_busy is 1 from the select update until active_src equals the one-hot form of sel_code.
- R8: This requirement covers a monitored source that is in use and has its failure-detect enable set. The monitors are src_rdy[3] for the external source and src_rdy[4] for the PLL. If that ready bit falls, then at the next reg_clk edge:
  - sel_code becomes 0 and osc_en becomes 5'b00001;
  - the source's fail_flag bit is set (bit 0 external, bit 1 PLL);
  - nmi is high for exactly one reg_clk cycle.
- R9: If a monitored source with its failure-detect enable set fails while it is not selected:
  - its enable bit clears and its fail_flag bit is set;
  - nmi stays 0 and sel_code is unchanged.
- R10: The failure-detect enables (address 3 bit 1 external, bit 2 PLL, shown on fd_enable[0] and fd_enable[1]) clear only by reset. A source whose failure-detect enable is 0 can fail without changing any register or raising nmi.
- R11: Writing 1 to address 3 bit 3 clears fail_flag[0], and writing 1 to bit 4 clears fail_flag[1]. Writing 0 to those bits leaves the flags unchanged.
- R12: The lock bit (address 3 bit 0) clears only by reset. While it is set, select and prescaler writes are ignored even with cfg_unlock high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| reg_clk | input | 1 | Register and monitor clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_clk | input | 5 | Oscillator clocks, bit i is source code i |
| src_rdy | input | 5 | Ready/lock/alive per source, reg_clk domain |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| cfg_unlock | input | 1 | Protection qualifier for protected fields |
| sys_clk | output | 1 | Glitch-free selected system clock |
| sel_code | output | 3 | Current select code |
| osc_en | output | 5 | Source enable bits |
| psc_set | output | 7 | Stored prescaler setting |
| lock_on | output | 1 | Lock bit |
| fd_enable | output | 2 | Failure-detect enables: [0] external, [1] PLL |
| fail_flag | output | 2 | Failure flags: [0] external, [1] PLL |
| nmi | output | 1 | One-cycle non-maskable interrupt pulse |
| active_src | output | 5 | One-hot source whose gate is open, synchronised to reg_clk |
| switch_busy | output | 1 | Gate state differs from the selection |

## Verification
Register fields and nmi change at the first reg_clk edge after the write or the ready drop, so the bench drives on a falling edge and reads the result at the following falling edge. active_src and switch_busy settle only after the two-plus-two source edges and the two-stage synchroniser, so the bench waits 30 reg_clk cycles before checking them. Exactly one cycle after a select write, it expects switch_busy high. The sys_clk period is timed between two rising edges once a switch has settled. A pulse-width monitor runs through every ordinary switch to catch a shortened pulse.

// File: rtl/clksw_pkg.sv
// Shared constants for the safe clock switch: source codes, register
// addresses and bit positions of the monitor register.
package clksw_pkg;
    localparam int NSRC  = 5;
    localparam int SELW  = 3;
    localparam int DATAW = 8;
    localparam int PSCW  = 7;
    localparam int ADDRW = 2;

    localparam logic [SELW-1:0] SRC_RC2M  = 3'd0;
    localparam logic [SELW-1:0] SRC_RC32M = 3'd1;
    localparam logic [SELW-1:0] SRC_RC32K = 3'd2;
    localparam logic [SELW-1:0] SRC_XOSC  = 3'd3;
    localparam logic [SELW-1:0] SRC_PLL   = 3'd4;

    localparam logic [NSRC-1:0] EN_RESET  = 5'b00001;

    typedef enum logic [ADDRW-1:0] {
        A_SEL   = 2'd0,
        A_OSCEN = 2'd1,
        A_PSC   = 2'd2,
        A_MON   = 2'd3
    } reg_addr_e;

    localparam int MON_LOCK  = 0;
    localparam int MON_XFDEN = 1;
    localparam int MON_PFDEN = 2;
    localparam int MON_XCLR  = 3;
    localparam int MON_PCLR  = 4;
endpackage

// File: rtl/clksw_sync.sv
// Multi-stage synchroniser for a vector of level signals.
// Assumes each bit is a slow level; no bus coherence is claimed.
module clksw_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    // Shift the sampled vector through the stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) pipe[s] <= '0;
        end else begin
            pipe[0] <= d;
            for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/clksw_gate.sv
// Per-source clock gate cell. The request is sampled on the rising edge
// of the source clock and then applied on the falling edge, so the gate
// only changes while the source clock is low. kill clears the cell at
// once; it is used when the source has been disabled (possibly because
// it stopped and can no longer clock the cell).
module clksw_gate (
    input  logic src_clk,
    input  logic rst_n,
    input  logic kill,
    input  logic req,
    output logic gate
);
    logic stage1;

    // First stage: capture the request on the source's rising edge.
    always_ff @(posedge src_clk or posedge kill) begin
        if (kill)        stage1 <= 1'b0;
        else if (!rst_n) stage1 <= 1'b0;
        else             stage1 <= req;
    end

    // Second stage: open or close the gate while the source clock is low.
    always_ff @(negedge src_clk or posedge kill) begin
        if (kill)        gate <= 1'b0;
        else if (!rst_n) gate <= 1'b0;
        else             gate <= stage1;
    end
endmodule

// File: rtl/clksw_regs.sv
// Register file and failure monitor of the clock switch (reg_clk domain).
// Assumes src_rdy is already synchronous to clk and that cfg_unlock is the
// result of an external timed-write sequence.
module clksw_regs
    import clksw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [ADDRW-1:0] wr_addr,
    input  logic [DATAW-1:0] wr_data,
    input  logic             cfg_unlock,
    input  logic [NSRC-1:0]  src_rdy,
    input  logic [NSRC-1:0]  active,
    output logic [SELW-1:0]  sel_q,
    output logic [NSRC-1:0]  en_q,
    output logic [PSCW-1:0]  psc_q,
    output logic             lock_q,
    output logic [1:0]       fden_q,
    output logic [1:0]       flag_q,
    output logic             nmi_q
);
    logic [NSRC-1:0] rdy_q;
    logic [NSRC-1:0] fall;
    logic            fail_x, fail_p, inuse_fail;
    logic            prot_ok;
    logic            sel_wr_ok;
    logic [NSRC-1:0] keep_mask;
    logic [NSRC-1:0] sel_onehot;
    logic [SELW-1:0] new_code;

    // Accept a select target only if it exists, is enabled and is ready.
    function automatic logic target_ok(input logic [SELW-1:0] c,
                                       input logic [NSRC-1:0] en,
                                       input logic [NSRC-1:0] rdy);
        if (c >= SELW'(NSRC)) return 1'b0;
        return en[c] & rdy[c];
    endfunction

    // Remember the previous ready levels to detect a falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) rdy_q <= '0;
        else        rdy_q <= src_rdy;
    end

    // Decode failures, protected-write qualification and the kept enables.
    always_comb begin
        fall       = rdy_q & ~src_rdy;
        fail_x     = fall[SRC_XOSC] & en_q[SRC_XOSC] & fden_q[0];
        fail_p     = fall[SRC_PLL]  & en_q[SRC_PLL]  & fden_q[1];
        inuse_fail = (fail_x && sel_q == SRC_XOSC) || (fail_p && sel_q == SRC_PLL);
        prot_ok    = wr_en & cfg_unlock;
        new_code   = wr_data[SELW-1:0];
        sel_wr_ok  = prot_ok && !lock_q && (wr_addr == A_SEL)
                     && target_ok(new_code, en_q, src_rdy);
        sel_onehot = NSRC'(1) << sel_q;
        keep_mask  = sel_onehot | active;
    end

    // Select and enable registers, with failure fallback taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= SRC_RC2M;
            en_q  <= EN_RESET;
        end else if (inuse_fail) begin
            sel_q <= SRC_RC2M;
            en_q  <= EN_RESET;
        end else begin
            if (sel_wr_ok) sel_q <= new_code;
            begin
                logic [NSRC-1:0] en_n;
                en_n = en_q;
                if (wr_en && wr_addr == A_OSCEN)
                    en_n = wr_data[NSRC-1:0] | (en_q & keep_mask);
                if (fail_x) en_n[SRC_XOSC] = 1'b0;
                if (fail_p) en_n[SRC_PLL]  = 1'b0;
                en_q <= en_n;
            end
        end
    end

    // Prescaler setting, protected and blocked by the lock.
    always_ff @(posedge clk) begin
        if (!rst_n)                                      psc_q <= '0;
        else if (prot_ok && !lock_q && wr_addr == A_PSC) psc_q <= wr_data[PSCW-1:0];
    end

    // Sticky lock and failure-detect enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= 1'b0;
            fden_q <= 2'b00;
        end else if (prot_ok && wr_addr == A_MON) begin
            lock_q    <= lock_q    | wr_data[MON_LOCK];
            fden_q[0] <= fden_q[0] | wr_data[MON_XFDEN];
            fden_q[1] <= fden_q[1] | wr_data[MON_PFDEN];
        end
    end

    // Failure flags: set by a detected failure, cleared by writing one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 2'b00;
        end else begin
            logic [1:0] f;
            f = flag_q;
            if (wr_en && wr_addr == A_MON) begin
                if (wr_data[MON_XCLR]) f[0] = 1'b0;
                if (wr_data[MON_PCLR]) f[1] = 1'b0;
            end
            if (fail_x) f[0] = 1'b1;
            if (fail_p) f[1] = 1'b1;
            flag_q <= f;
        end
    end

    // One-cycle interrupt pulse on an in-use failure.
    always_ff @(posedge clk) begin
        if (!rst_n) nmi_q <= 1'b0;
        else        nmi_q <= inuse_fail;
    end

    // R12
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> lock_q);
    // R10
    fden_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((fden_q & $past(fden_q)) == $past(fden_q)));
    // R6
    active_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_q[sel_q]);
    // R4
    sel_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_q < SELW'(NSRC));
    // R8
    nmi_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_q |-> (sel_q == SRC_RC2M && en_q == EN_RESET));
    // R8
    nmi_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_q |=> !nmi_q);
endmodule

// File: rtl/safe_clk_switch.sv
// Top of the safe clock switch. Holds the register file, one gate cell
// per source and a synchroniser that reports the open gates to reg_clk.
// Assumes the source clocks are free-running while enabled and that
// rst_n is held long enough for every enabled source to see it.
module safe_clk_switch
    import clksw_pkg::*;
(
    input  logic             reg_clk,
    input  logic             rst_n,
    input  logic [4:0]       src_clk,
    input  logic [4:0]       src_rdy,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [7:0]       wr_data,
    input  logic             cfg_unlock,
    output logic             sys_clk,
    output logic [2:0]       sel_code,
    output logic [4:0]       osc_en,
    output logic [6:0]       psc_set,
    output logic             lock_on,
    output logic [1:0]       fd_enable,
    output logic [1:0]       fail_flag,
    output logic             nmi,
    output logic [4:0]       active_src,
    output logic             switch_busy
);
    logic [NSRC-1:0] gate;
    logic [NSRC-1:0] req;
    logic [NSRC-1:0] kill;
    logic [NSRC-1:0] sel_onehot;
    logic [NSRC-1:0] active;

    clksw_regs u_regs (
        .clk        (reg_clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .cfg_unlock (cfg_unlock),
        .src_rdy    (src_rdy),
        .active     (active),
        .sel_q      (sel_code),
        .en_q       (osc_en),
        .psc_q      (psc_set),
        .lock_q     (lock_on),
        .fden_q     (fd_enable),
        .flag_q     (fail_flag),
        .nmi_q      (nmi)
    );

    assign sel_onehot = NSRC'(1) << sel_code;

    // One gate per source; a gate may open only when every other is shut.
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        localparam logic [NSRC-1:0] SELF = NSRC'(1) << i;
        assign req[i]  = sel_onehot[i] & ~|(gate & ~SELF);
        assign kill[i] = ~osc_en[i];
        clksw_gate u_gate (
            .src_clk (src_clk[i]),
            .rst_n   (rst_n),
            .kill    (kill[i]),
            .req     (req[i]),
            .gate    (gate[i])
        );
    end

    // Glitch-free output: at most one gated source is ever passed.
    assign sys_clk = |(src_clk & gate);

    clksw_sync #(.W(NSRC), .STAGES(2)) u_sync (
        .clk   (reg_clk),
        .rst_n (rst_n),
        .d     (gate),
        .q     (active)
    );

    assign active_src  = active;
    assign switch_busy = (active != sel_onehot);

    // R7
    gate_onehot_chk: assert property (@(posedge reg_clk) disable iff (!rst_n)
        $onehot0(gate));
    // R7
    active_onehot_chk: assert property (@(posedge reg_clk) disable iff (!rst_n)
        $onehot0(active));
endmodule

// File: tb/test_safe_clk_switch.sv
`timescale 1ns/1ps
module test_safe_clk_switch;
    logic       reg_clk = 1'b0;
    logic       rst_n   = 1'b0;
    logic       c0 = 0, c1 = 0, c2 = 0, c3 = 0, c4 = 0;
    logic [4:0] src_clk;
    logic [4:0] src_rdy = 5'h1F;
    logic       wr_en = 0;
    logic [1:0] wr_addr = 0;
    logic [7:0] wr_data = 0;
    logic       cfg_unlock = 0;
    logic       sys_clk, lock_on, nmi, switch_busy;
    logic [2:0] sel_code;
    logic [4:0] osc_en, active_src;
    logic [6:0] psc_set;
    logic [1:0] fd_enable, fail_flag;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 0;

    always #10  reg_clk = ~reg_clk;  // 50 MHz
    always #7   c0 = ~c0;
    always #3   c1 = ~c1;
    always #15  c2 = ~c2;
    always #5   c3 = ~c3;
    always #2   c4 = ~c4;
    assign src_clk = {c4, c3, c2, c1, c0};

    safe_clk_switch i_safe_clk_switch (
        .reg_clk(reg_clk), .rst_n(rst_n), .src_clk(src_clk), .src_rdy(src_rdy),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .cfg_unlock(cfg_unlock),
        .sys_clk(sys_clk), .sel_code(sel_code), .osc_en(osc_en), .psc_set(psc_set),
        .lock_on(lock_on), .fd_enable(fd_enable), .fail_flag(fail_flag), .nmi(nmi),
        .active_src(active_src), .switch_busy(switch_busy)
    );

    // Pulse-width monitor on sys_clk for R7.
    realtime last_edge = 0;
    realtime min_w = 1000.0;
    bit      mon_on = 0;
    always @(sys_clk) begin
        if (mon_on && ($realtime - last_edge) < min_w) min_w = $realtime - last_edge;
        last_edge = $realtime;
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic u);
        @(negedge reg_clk);
        wr_en = 1; wr_addr = a; wr_data = d; cfg_unlock = u;
        @(negedge reg_clk);
        wr_en = 0; cfg_unlock = 0;
    endtask

    task automatic settle();
        repeat (30) @(negedge reg_clk);
    endtask

    task automatic period(output realtime p);
        realtime t0;
        @(posedge sys_clk); t0 = $realtime;
        @(posedge sys_clk); p = $realtime - t0;
    endtask

    typedef struct packed {
        logic [1:0] a;
        logic [7:0] d;
        logic       u;
        logic [4:0] r;
        logic [2:0] s;
        logic [4:0] e;
    } vec_t;
    localparam int NV = 14;
    localparam vec_t VT [NV] = '{
        '{2'd1, 8'h1F, 1'b0, 5'h1F, 3'd0, 5'h1F},  // R6 set enables
        '{2'd0, 8'h01, 1'b0, 5'h1F, 3'd0, 5'h1F},  // R5 no unlock
        '{2'd0, 8'h01, 1'b1, 5'h1F, 3'd1, 5'h1F},  // R2 to 32 MHz
        '{2'd0, 8'h02, 1'b1, 5'h1B, 3'd1, 5'h1F},  // R3 target not ready
        '{2'd0, 8'h05, 1'b1, 5'h1F, 3'd1, 5'h1F},  // R4 reserved
        '{2'd0, 8'h07, 1'b1, 5'h1F, 3'd1, 5'h1F},  // R4 reserved
        '{2'd1, 8'h00, 1'b0, 5'h1F, 3'd1, 5'h02},  // R6 active kept
        '{2'd0, 8'h03, 1'b1, 5'h1F, 3'd1, 5'h02},  // R3 target disabled
        '{2'd1, 8'h0A, 1'b0, 5'h1F, 3'd1, 5'h0A},  // R6
        '{2'd0, 8'h03, 1'b1, 5'h1F, 3'd3, 5'h0A},  // R2 to external
        '{2'd1, 8'h00, 1'b0, 5'h1F, 3'd3, 5'h08},  // R6 active kept
        '{2'd1, 8'h19, 1'b0, 5'h1F, 3'd3, 5'h19},  // R6
        '{2'd0, 8'h04, 1'b1, 5'h1F, 3'd4, 5'h19},  // R2 to PLL
        '{2'd0, 8'h00, 1'b1, 5'h1F, 3'd0, 5'h19}   // R2 back to 2 MHz
    };
    localparam string TAGS [NV] = '{"R6", "R5", "R2", "R3", "R4", "R4", "R6",
                                   "R3", "R6", "R2", "R6", "R6", "R2", "R2"};

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge reg_clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        realtime p;
        repeat (5) @(negedge reg_clk);
        rst_n = 1;
        @(negedge reg_clk);
        // R1 reset state
        chk("R1", "sel", sel_code, 0);
        chk("R1", "en", osc_en, 5'h01);
        chk("R1", "psc", psc_set, 0);
        chk("R1", "lock", lock_on, 0);
        chk("R1", "fden", fd_enable, 0);
        chk("R1", "flag", fail_flag, 0);
        chk("R1", "nmi", nmi, 0);
        settle();
        chk("R1", "active", active_src, 5'h01);
        mon_on = 1;

        for (int k = 0; k < NV; k++) begin
            src_rdy = VT[k].r;
            wr(VT[k].a, VT[k].d, VT[k].u);
            chk(TAGS[k], $sformatf("vec%0d sel", k), sel_code, VT[k].s);
            chk(TAGS[k], $sformatf("vec%0d en", k), osc_en, VT[k].e);
            settle();
            // R7 switch finished onto the selected source
            chk("R7", $sformatf("vec%0d active", k), active_src, 5'h01 << VT[k].s);
            chk("R7", $sformatf("vec%0d busy", k), switch_busy, 0);
        end
        src_rdy = 5'h1F;

        // R2 output period follows the selected source
        wr(2'd1, 8'h1F, 0);
        wr(2'd0, 8'h01, 1); settle();
        period(p); chk("R2", "period 32M", int'(p * 10), 60);
        wr(2'd0, 8'h02, 1); settle();
        period(p); chk("R2", "period 32k", int'(p * 10), 300);
        wr(2'd0, 8'h04, 1); settle();
        period(p); chk("R2", "period PLL", int'(p * 10), 40);

        // R7 busy right after the select update
        wr(2'd0, 8'h03, 1);
        chk("R7", "busy", switch_busy, 1);
        settle();
        // R6 clearing a source whose gate is still open
        wr(2'd0, 8'h00, 1);
        @(negedge reg_clk);
        wr_en = 1; wr_addr = 2'd1; wr_data = 8'h01;
        @(negedge reg_clk);
        wr_en = 0;
        chk("R6", "old source kept", osc_en, 5'h09);
        settle();
        chk("R7", "min pulse ok", (min_w >= 1.99) ? 1 : 0, 1);

        // R9 failure of an unused monitored source
        wr(2'd1, 8'h19, 0);
        wr(2'd3, 8'h06, 1);
        chk("R10", "fden set", fd_enable, 2'b11);
        @(negedge reg_clk); src_rdy[3] = 0;
        @(negedge reg_clk);
        chk("R9", "en", osc_en, 5'h11);
        chk("R9", "flag", fail_flag, 2'b01);
        chk("R9", "nmi", nmi, 0);
        chk("R9", "sel", sel_code, 0);
        src_rdy[3] = 1;

        // R11 write-one-to-clear, zero has no effect; R10 sticky enables
        wr(2'd3, 8'h00, 1);
        chk("R11", "zero keeps flag", fail_flag, 2'b01);
        chk("R10", "fden sticky", fd_enable, 2'b11);
        wr(2'd3, 8'h08, 0);
        chk("R11", "flag cleared", fail_flag, 2'b00);

        // R8 in-use PLL failure
        wr(2'd0, 8'h04, 1); settle();
        chk("R8", "pll active", active_src, 5'h10);
        mon_on = 0;
        @(negedge reg_clk); src_rdy[4] = 0;
        @(negedge reg_clk);
        chk("R8", "nmi", nmi, 1);
        chk("R8", "sel", sel_code, 0);
        chk("R8", "en", osc_en, 5'h01);
        chk("R8", "flag", fail_flag, 2'b10);
        @(negedge reg_clk);
        chk("R8", "nmi pulse", nmi, 0);
        settle();
        chk("R8", "fallback active", active_src, 5'h01);
        src_rdy[4] = 1;

        // R5 and R12 prescaler and lock
        wr(2'd2, 8'h15, 1);
        chk("R5", "psc unlocked", psc_set, 7'h15);
        wr(2'd2, 8'h22, 0);
        chk("R5", "psc no unlock", psc_set, 7'h15);
        wr(2'd3, 8'h01, 0);
        chk("R5", "lock no unlock", lock_on, 0);
        wr(2'd3, 8'h01, 1);
        chk("R12", "lock set", lock_on, 1);
        wr(2'd1, 8'h03, 0);
        wr(2'd0, 8'h01, 1);
        chk("R12", "sel blocked", sel_code, 0);
        wr(2'd2, 8'h33, 1);
        chk("R12", "psc blocked", psc_set, 7'h15);
        wr(2'd3, 8'h00, 1);
        chk("R12", "lock sticky", lock_on, 1);

        // R1 reset again mid-run
        @(negedge reg_clk); rst_n = 0;
        repeat (4) @(negedge reg_clk);
        rst_n = 1;
        @(negedge reg_clk);
        chk("R1", "lock cleared", lock_on, 0);
        chk("R1", "fden cleared", fd_enable, 0);
        chk("R1", "flags cleared", fail_flag, 0);
        chk("R1", "psc cleared", psc_set, 0);
        settle();
        chk("R1", "active after reset", active_src, 5'h01);

        // R10 unmonitored failure changes nothing
        wr(2'd1, 8'h11, 0);
        wr(2'd0, 8'h04, 1); settle();
        @(negedge reg_clk); src_rdy[4] = 0;
        @(negedge reg_clk);
        chk("R10", "sel", sel_code, 4);
        chk("R10", "en", osc_en, 5'h11);
        chk("R10", "flag", fail_flag, 0);
        chk("R10", "nmi", nmi, 0);
        src_rdy[4] = 1;

        done = 1;
        summary();
        $finish;
    end
endmodule